// File: doc/BRIEF.md
# Dual-Convention Host Register Port

This block is a slave on a 16-bit host bus. It gives the host read and write access to a small internal register file. Two host bus styles share the same pins, and a static mode input chooses between them. In split-strobe style there is one active-low read strobe and one active-low write strobe. In direction-select style one line gives the transfer direction and a second line is an active-high data strobe. Every access is qualified by an active-low chip select. The register index comes from an address that is captured by an address-latch-enable input, so hosts with a multiplexed address/data bus are supported. Hosts with a separate address bus simply tie the latch enable high.

Host pins are asynchronous to the system clock. The strobe, chip select, latch enable, address and data pins are carried through a two-flop synchroniser before any write is decided. The read-drive enable is taken from a single sampling flop, so the bus is released quickly.

Two internal interrupt requests leave the block on pins whose polarity follows the bus style. In split-strobe style a program input picks one of two write timing variants. In direction-select style that input is ignored.

Top module: `hostbus_slave`

## Requirements
- R1: After reset the bus drive enable is low, and every register in range reads back as 0.
- R2: With mode low (split-strobe) and program input low, a write takes place while chip select is low and the write pin is low. It is committed when the strobe is released.
- R3: In split-strobe style, chip select low and read pin low make the drive enable rise on the next clock. The data output then carries the contents of the latched register index.
- R4: With mode high (direction-select), read pin high together with write pin high is a read, and read pin low together with write pin high is a write committed on strobe release. With write pin low nothing is driven.
- R5: While chip select is high, no write changes any register and the bus is not driven.
- R6: The drive enable falls no later than one clock after chip select or the read qualifier goes inactive at the pins.
- R7: The interrupt pins equal their requests in split-strobe style and equal their inverses in direction-select style.
- R8: In split-strobe style with program input high, a write is committed on the strobe's asserting edge, using the data present then. In direction-select style the program input has no effect.
- R9: The address is captured while latch enable is high and held while it is low. The register index is the full captured 8-bit address value.
- R10: An index of NUM_REGS (64) or more is not stored, so it does not alias onto a lower register, and it reads back as 0.
- R11: For a commit on release, the data used is the data sampled on the last cycle of the active strobe. Data that changes together with the release is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_dir | input | 1 | Bus style: 1 = direction-select, 0 = split-strobe |
| wr_prog | input | 1 | Split-strobe write timing: 1 = commit on assert, 0 = commit on release |
| ale | input | 1 | Address latch enable, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_pin | input | 1 | Read strobe (split) or direction, 1 = read (direction-select) |
| wr_pin | input | 1 | Write strobe, active low (split) or data strobe, active high (direction-select) |
| addr | input | 8 | Register address from the host |
| host_din | input | 16 | Write data from the host |
| host_dout | output | 16 | Read data toward the host |
| host_doe | output | 1 | Tri-state drive enable for host_dout |
| irq_a_req | input | 1 | Internal interrupt request A, active high |
| irq_b_req | input | 1 | Internal interrupt request B, active high |
| irq_a_pin | output | 1 | Interrupt A pin, polarity set by the mode |
| irq_b_pin | output | 1 | Interrupt B pin, polarity set by the mode |

## Verification
Writes are run in each bus style and each timing variant. In every write the data changes while the strobe is held, so the read-back value shows whether the commit used the asserting edge or the last active cycle. The same write is also tried with chip select high, and to an index of 70. Index 70 would fold onto register 6, so a read of register 6 shows whether the out-of-range write was dropped or aliased. The address pins are moved while latch enable is low, which separates a held latch from a transparent one. A bench model, updated on every clock, also tracks the drive enable, the read data and both interrupt pins while the request lines and the mode toggle.

// File: rtl/hostbus_slave.sv
`timescale 1ns/1ps
module hostbus_slave #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_dir,
  input  logic              wr_prog,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              rd_pin,
  input  logic              wr_pin,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_doe,
  input  logic              irq_a_req,
  input  logic              irq_b_req,
  output logic              irq_a_pin,
  output logic              irq_b_pin
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int BUS_W = ADDR_W + DATA_W + 4;
  localparam logic [BUS_W-1:0] IDLE = {2'b01, {(BUS_W-2){1'b0}}};

  function automatic logic rd_qual(input logic m, input logic rd, input logic wr);
    return m ? (rd & wr) : ~rd;
  endfunction

  function automatic logic wr_qual(input logic m, input logic rd, input logic wr);
    return m ? (~rd & wr) : ~wr;
  endfunction

  logic [BUS_W-1:0] raw, p_q, s_q;
  assign raw = {ale, cs_n, rd_pin, wr_pin, addr, host_din};

  logic              s_ale, s_cs_n, s_rd, s_wr;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  assign s_ale  = s_q[BUS_W-1];
  assign s_cs_n = s_q[BUS_W-2];
  assign s_rd   = s_q[BUS_W-3];
  assign s_wr   = s_q[BUS_W-4];
  assign s_addr = s_q[DATA_W +: ADDR_W];
  assign s_data = s_q[DATA_W-1:0];

  logic [ADDR_W-1:0] al_q, idx_h;
  logic [DATA_W-1:0] data_h;
  logic              wr_prev;
  logic [DATA_W-1:0] regs [NUM_REGS];

  logic              wr_now, early, commit;
  logic [ADDR_W-1:0] c_idx;
  logic [DATA_W-1:0] c_data;
  assign wr_now = ~s_cs_n & wr_qual(mode_dir, s_rd, s_wr);
  assign early  = ~mode_dir & wr_prog;
  assign commit = early ? (wr_now & ~wr_prev) : (~wr_now & wr_prev);
  assign c_idx  = early ? al_q : idx_h;
  assign c_data = early ? s_data : data_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q     <= IDLE;
      s_q     <= IDLE;
      al_q    <= '0;
      idx_h   <= '0;
      data_h  <= '0;
      wr_prev <= 1'b0;
    end else begin
      p_q     <= raw;
      s_q     <= p_q;
      wr_prev <= wr_now;
      if (wr_now) begin
        idx_h  <= al_q;
        data_h <= s_data;
      end
      if (s_ale) al_q <= s_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (commit && (int'(c_idx) < NUM_REGS)) begin
      regs[c_idx[IDX_W-1:0]] <= c_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_doe  <= 1'b0;
      host_dout <= '0;
    end else begin
      host_doe  <= ~cs_n & rd_qual(mode_dir, rd_pin, wr_pin);
      host_dout <= (int'(al_q) < NUM_REGS) ? regs[al_q[IDX_W-1:0]] : '0;
    end
  end

  assign irq_a_pin = mode_dir ? ~irq_a_req : irq_a_req;
  assign irq_b_pin = mode_dir ? ~irq_b_req : irq_b_req;
endmodule

module hostbus_slave_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_dir,
  input logic              cs_n,
  input logic              rd_pin,
  input logic              wr_pin,
  input logic              host_doe,
  input logic              irq_a_req,
  input logic              irq_b_req,
  input logic              irq_a_pin,
  input logic              irq_b_pin
);
  assert_drive_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_doe |-> !$past(cs_n));
  assert_release_on_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !host_doe);
  assert_split_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_dir && rd_pin) |=> !host_doe);
  assert_dir_strobe_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dir && !wr_pin) |=> !host_doe);
  assert_irq_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a_req == irq_b_req) |-> (irq_a_pin == irq_b_pin));
endmodule

bind hostbus_slave hostbus_slave_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/hostbus_slave_tb.sv
`timescale 1ns/1ps
module hostbus_slave_tb;
  localparam int NREG = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_dir = 1'b0, wr_prog = 1'b0, ale = 1'b0, cs_n = 1'b1;
  logic rd_pin = 1'b1, wr_pin = 1'b1;
  logic [7:0] addr = '0;
  logic [15:0] host_din = '0, host_dout;
  logic host_doe, irq_a_req = 1'b0, irq_b_req = 1'b0, irq_a_pin, irq_b_pin;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hostbus_slave u_dut (.*);

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  logic [15:0] m_regs [NREG];
  int m_al, m_ih;
  logic [15:0] m_dh;
  bit m_wp;
  logic [27:0] m_r1, m_r2;
  logic exp_doe;
  logic [15:0] exp_dout;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_regs[i]) m_regs[i] = '0;
      m_al = 0; m_ih = 0; m_dh = '0; m_wp = 0;
      m_r1 = {2'b01, 26'd0}; m_r2 = {2'b01, 26'd0};
      exp_doe = 1'b0; exp_dout = '0;
    end else begin
      bit wn, early, go;
      int idx;
      logic [15:0] d;
      exp_doe = !cs_n && (mode_dir ? (rd_pin && wr_pin) : !rd_pin);
      exp_dout = (m_al < NREG) ? m_regs[m_al] : 16'h0;
      wn = !m_r2[26] && (mode_dir ? (!m_r2[25] && m_r2[24]) : !m_r2[24]);
      early = !mode_dir && wr_prog;
      go = early ? (wn && !m_wp) : (!wn && m_wp);
      idx = early ? m_al : m_ih;
      d = early ? m_r2[15:0] : m_dh;
      if (go && idx < NREG) m_regs[idx] = d;
      if (wn) begin m_ih = m_al; m_dh = m_r2[15:0]; end
      if (m_r2[27]) m_al = int'(m_r2[23:16]);
      m_wp = wn;
      m_r2 = m_r1;
      m_r1 = {ale, cs_n, rd_pin, wr_pin, addr, host_din};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 drive enable vs model", {15'd0, host_doe}, {15'd0, exp_doe});
      if (exp_doe) check("R3 read data vs model", host_dout, exp_dout);
      check("R7 irq A vs model", {15'd0, irq_a_pin}, {15'd0, mode_dir ? !irq_a_req : irq_a_req});
      check("R7 irq B vs model", {15'd0, irq_b_pin}, {15'd0, mode_dir ? !irq_b_req : irq_b_req});
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_pins();
    cs_n = 1'b1;
    rd_pin = mode_dir ? 1'b1 : 1'b1;
    wr_pin = mode_dir ? 1'b0 : 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] a);
    @(negedge clk); ale = 1'b1; addr = a;
    wait_n(3); ale = 1'b0;
    wait_n(1);
  endtask

  task automatic do_write(input logic [15:0] d1, input logic [15:0] d2, input bit sel);
    @(negedge clk);
    cs_n = !sel; host_din = d1;
    if (mode_dir) begin rd_pin = 1'b0; wr_pin = 1'b1; end else wr_pin = 1'b0;
    wait_n(4); host_din = d2;
    wait_n(4);
    idle_pins(); host_din = 16'hDEAD;
    wait_n(4);
  endtask

  task automatic do_read(input string tag, input logic [15:0] exp);
    @(negedge clk);
    cs_n = 1'b0;
    if (mode_dir) begin rd_pin = 1'b1; wr_pin = 1'b1; end else rd_pin = 1'b0;
    wait_n(4);
    check({tag, " drive"}, {15'd0, host_doe}, 16'd1);
    check(tag, host_dout, exp);
    idle_pins();
    wait_n(1);
    check("R6 released after read", {15'd0, host_doe}, 16'd0);
    wait_n(2);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    check("R1 drive low after reset", {15'd0, host_doe}, 16'd0);
    set_addr(8'd3);
    do_read("R1 reset register value", 16'h0000);

    set_addr(8'd5);
    do_write(16'hA1A1, 16'hA2A2, 1'b1);
    do_read("R2 R11 split late commit", 16'hA2A2);

    wr_prog = 1'b1;
    set_addr(8'd6);
    do_write(16'hB1B1, 16'hB2B2, 1'b1);
    do_read("R8 split early commit", 16'hB1B1);
    wr_prog = 1'b0;

    set_addr(8'd5);
    do_write(16'h5555, 16'h6666, 1'b0);
    do_read("R5 write without select ignored", 16'hA2A2);
    @(negedge clk); rd_pin = 1'b0; cs_n = 1'b1;
    wait_n(2);
    check("R5 no drive without select", {15'd0, host_doe}, 16'd0);
    idle_pins(); wait_n(2);

    set_addr(8'd70);
    do_write(16'hC1C1, 16'hC1C1, 1'b1);
    do_read("R10 out of range reads zero", 16'h0000);
    set_addr(8'd6);
    do_read("R10 no alias onto register 6", 16'hB1B1);

    set_addr(8'd5);
    @(negedge clk); addr = 8'd6;
    wait_n(3);
    do_read("R9 latch holds while ale low", 16'hA2A2);
    @(negedge clk); ale = 1'b1;
    wait_n(3);
    do_read("R9 transparent while ale high", 16'hB1B1);
    @(negedge clk); ale = 1'b0; wait_n(2);

    irq_a_req = 1'b1; wait_n(2);
    check("R7 split irq A high", {15'd0, irq_a_pin}, 16'd1);
    check("R7 split irq B low", {15'd0, irq_b_pin}, 16'd0);

    @(negedge clk); mode_dir = 1'b1; wr_prog = 1'b1; idle_pins();
    wait_n(3);
    check("R7 dir irq A inverted", {15'd0, irq_a_pin}, 16'd0);
    check("R7 dir irq B inverted", {15'd0, irq_b_pin}, 16'd1);
    set_addr(8'd9);
    do_write(16'hD1D1, 16'hD2D2, 1'b1);
    do_read("R4 R8 dir write and read, prog ignored", 16'hD2D2);
    @(negedge clk); cs_n = 1'b0; rd_pin = 1'b1; wr_pin = 1'b0;
    wait_n(3);
    check("R4 no drive with strobe low", {15'd0, host_doe}, 16'd0);
    idle_pins(); irq_b_req = 1'b1; irq_a_req = 1'b0;
    wait_n(3);
    check("R7 dir irq A idle high", {15'd0, irq_a_pin}, 16'd1);

    @(negedge clk); mode_dir = 1'b0; wr_prog = 1'b0; idle_pins();
    wait_n(3);
    set_addr(8'd9);
    do_read("R2 register kept across mode change", 16'hD2D2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog expired got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule